// File: doc/BRIEF.md
# Table-Driven FM Tone Synthesizer

This block turns a stream of byte-wide data samples into a sampled sine tone. The frequency of the tone follows the current data value in linear steps. The lowest code gives `F_LO` and the highest gives `F_HI`. With the defaults that is 1650 Hz to 2450 Hz, about 3.14 Hz per code, at an output rate of 14.4 kHz.

An output tick is a one-clock strobe on `tick`. On each tick a 16-bit phase accumulator advances by the increment that belongs to the current code. The accumulator's top bit picks the half-period of the wave. The bits below it address a table that holds only the positive half of a sine period, and the negative half is formed by negating the table value.

Each data byte is held for `SYM_TICKS` ticks, 120 by default, so the symbol rate is 120 per second at the default tick rate. A new byte is taken with a valid/ready handshake on the last tick of a symbol. The increment of a new code is applied only at the next zero crossing of the wave, and the phase is never reset.

Top module: `fm_tone_synth`

## Requirements
- R1: While `rst` is high (synchronous, active high), and in the first cycle after it is released, `sample` is 0 and `underrun` is 0. The first tick after reset is a symbol boundary, so `in_ready` is high on that tick.
- R2: The phase increment for code c is round((F_LO·(C−1) + c·(F_HI−F_LO))·2^PHASE_W / ((C−1)·F_TICK)), where C = 2^DATA_W. The division rounds half up. After reset the increment is the one for code 0.
- R3: The phase accumulator advances, modulo 2^PHASE_W, by the active increment on each cycle with `tick` high. On a cycle with `tick` low, every output and all state stay unchanged.
- R4: The magnitude m(k) for half-table index k is AMPMAX·16·k·(N−k) / (5·N² − 4·k·(N−k)), rounded down, where N = 2^SINE_AW and AMPMAX = 2^(AMP_W−1)−1. The index k is the phase bits directly below the top bit. `sample` is +m(k) when the phase's top bit is 0 and −m(k) when it is 1.
- R5: A symbol lasts exactly `SYM_TICKS` ticks. `in_ready` is high only on the tick that ends a symbol, and a byte is taken when `in_valid` is high on that tick.
- R6: The active increment changes only on a tick where the phase's top bit toggles. The new value is the increment of the code that was held during that tick, and it is used from the following tick onward.
- R7: A constant input code gives one continuous tone. The phase is not reset at symbol boundaries.
- R8: If `in_valid` is low on a boundary tick, the previous code is kept for the next symbol and `underrun` goes high. `underrun` goes low again at the next boundary where a byte is taken.
- R9: Over one second of ticks at a constant code of 0x00, 0x80 or 0xFF, the count of full output cycles is within one code step (plus quantization) of F_LO + c·(F_HI−F_LO)/(C−1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Output-rate enable, one clock per output sample |
| in_valid | input | 1 | A data byte is offered |
| in_data | input | DATA_W | Data byte that selects the frequency |
| in_ready | output | 1 | High on the tick that ends a symbol |
| sample | output | AMP_W | Signed sine sample for the current phase |
| underrun | output | 1 | The current symbol repeats the previous code because no byte was offered |

## Verification
The bench builds the block with its default parameters: a 256-entry step table, a 64-entry half-sine table, 120-tick symbols and a 14.4 kHz tick rate. With these values, one simulated second of ticks per code fits the cycle budget, so the measured tone frequency can be compared with the nominal frequency at both ends and the middle of the code range. A pseudo-random stretch with gaps in `tick` and `in_valid` covers the hold behaviour, symbols that underrun, and code changes that wait for a zero crossing while symbols are still running.

// File: rtl/fm_tone_synth.sv
module fm_tone_synth #(
  parameter int DATA_W    = 8,
  parameter int PHASE_W   = 16,
  parameter int SINE_AW   = 6,
  parameter int AMP_W     = 12,
  parameter int SYM_TICKS = 120,
  parameter int F_LO      = 1650,
  parameter int F_HI      = 2450,
  parameter int F_TICK    = 14400
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    in_valid,
  input  logic [DATA_W-1:0]       in_data,
  output logic                    in_ready,
  output logic signed [AMP_W-1:0] sample,
  output logic                    underrun
);
  localparam int CODES   = 2 ** DATA_W;
  localparam int HALF_N  = 2 ** SINE_AW;
  localparam int CNT_W   = $clog2(SYM_TICKS);
  localparam int MAG_W   = AMP_W - 1;
  localparam int AMP_MAX = 2 ** MAG_W - 1;

  function automatic logic [PHASE_W-1:0] step_of(input int c);
    longint num, den;
    num = longint'(F_LO) * (longint'(1) << PHASE_W) * longint'(CODES - 1)
        + longint'(c) * longint'(F_HI - F_LO) * (longint'(1) << PHASE_W);
    den = longint'(CODES - 1) * longint'(F_TICK);
    return PHASE_W'((num + den / 2) / den);
  endfunction

  function automatic logic [MAG_W-1:0] mag_of(input int k);
    longint p;
    p = longint'(k) * longint'(HALF_N - k);
    return MAG_W'((longint'(AMP_MAX) * 16 * p) /
                  (5 * longint'(HALF_N) * longint'(HALF_N) - 4 * p));
  endfunction

  logic [PHASE_W-1:0] step_tab [CODES];
  logic [MAG_W-1:0]   half_tab [HALF_N];

  for (genvar i = 0; i < CODES; i++) begin : g_step
    assign step_tab[i] = step_of(i);
  end
  for (genvar j = 0; j < HALF_N; j++) begin : g_half
    assign half_tab[j] = mag_of(j);
  end

  logic [PHASE_W-1:0] phase, cur_inc, nxt_phase;
  logic [DATA_W-1:0]  code_q;
  logic [CNT_W-1:0]   cnt;
  logic               last, flip;
  logic [MAG_W-1:0]   mag;

  assign last      = (cnt == CNT_W'(SYM_TICKS - 1));
  assign in_ready  = tick & last;
  assign nxt_phase = phase + cur_inc;
  assign flip      = nxt_phase[PHASE_W-1] ^ phase[PHASE_W-1];
  assign mag       = half_tab[phase[PHASE_W-2 -: SINE_AW]];

  always_comb begin
    if (phase[PHASE_W-1]) sample = -$signed({1'b0, mag});
    else                  sample =  $signed({1'b0, mag});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      cur_inc  <= step_of(0);
      code_q   <= '0;
      cnt      <= CNT_W'(SYM_TICKS - 1);
      underrun <= 1'b0;
    end else if (tick) begin
      phase <= nxt_phase;
      if (flip) cur_inc <= step_tab[code_q];
      if (last) begin
        cnt <= '0;
        if (in_valid) begin
          code_q   <= in_data;
          underrun <= 1'b0;
        end else begin
          underrun <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fm_tone_synth_chk.sv
module fm_tone_synth_chk #(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic               in_valid,
  input logic               in_ready,
  input logic               underrun,
  input logic [PHASE_W-1:0] phase,
  input logic [PHASE_W-1:0] cur_inc,
  input logic [DATA_W-1:0]  code_q
);
  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase));

  assert_ready_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tick);

  assert_inc_at_crossing_R6: assert property (@(posedge clk) disable iff (rst)
    $stable(phase[PHASE_W-1]) |-> $stable(cur_inc));

  assert_underrun_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> (underrun && $stable(code_q)));

  assert_take_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid) |=> !underrun);
endmodule

bind fm_tone_synth fm_tone_synth_chk #(.DATA_W(DATA_W), .PHASE_W(PHASE_W)) chk (
  .clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
  .underrun(underrun), .phase(phase), .cur_inc(cur_inc), .code_q(code_q)
);

// File: tb/fm_tone_synth_test.sv
module fm_tone_synth_test;
  localparam int PERIOD = 10;
  localparam int SYM    = 120;
  localparam int PW     = 16;
  localparam int AW     = 6;
  localparam int AMPW   = 12;

  logic clk = 0, rst = 1, tick = 0, in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready, underrun;
  logic signed [AMPW-1:0] sample;

  fm_tone_synth uut (.clk(clk), .rst(rst), .tick(tick), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .sample(sample), .underrun(underrun));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  longint m_phase, m_cur;
  int m_code, m_cnt, m_under;
  int cyc_cnt, prev_neg, meas_on;

  function automatic longint inc_of(int c);
    longint num, den;
    num = 1650 * 65536 * 255 + longint'(c) * 800 * 65536;
    den = 255 * 14400;
    return (num + den / 2) / den;
  endfunction

  function automatic int exp_sample(longint ph);
    longint k, p, m;
    k = (ph >> (PW - 1 - AW)) & ((1 << AW) - 1);
    p = k * (64 - k);
    m = (2047 * 16 * p) / (5 * 64 * 64 - 4 * p);
    return ((ph >> (PW - 1)) & 1) ? -int'(m) : int'(m);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic t);
    longint nxt;
    int neg;
    in_valid = v; in_data = d; tick = t;
    #1;
    check("R5 in_ready", int'(in_ready), (t && m_cnt == SYM - 1) ? 1 : 0);
    @(posedge clk);
    if (t) begin
      nxt = (m_phase + m_cur) & 64'hFFFF;
      if (((nxt >> 15) & 1) != ((m_phase >> 15) & 1)) m_cur = inc_of(m_code);
      if (m_cnt == SYM - 1) begin
        m_cnt = 0;
        if (v) begin m_code = d; m_under = 0; end
        else m_under = 1;
      end else m_cnt++;
      m_phase = nxt;
    end
    @(negedge clk);
    if (t) check("R4 R6 R7 sample", int'(sample), exp_sample(m_phase));
    else   check("R3 hold sample", int'(sample), exp_sample(m_phase));
    check("R8 underrun", int'(underrun), m_under);
    neg = (sample < 0) ? 1 : 0;
    if (meas_on && neg && !prev_neg) cyc_cnt++;
    prev_neg = neg;
  endtask

  task automatic measure(input int code);
    int lo, hi, nom;
    for (int i = 0; i < 2 * SYM; i++) step(1, 8'(code), 1);
    cyc_cnt = 0; meas_on = 1;
    for (int i = 0; i < 14400; i++) step(1, 8'(code), 1);
    meas_on = 0;
    nom = 1650 * 255 + code * 800;
    lo = nom - 4 * 255; hi = nom + 4 * 255;
    checks++;
    if (cyc_cnt * 255 < lo || cyc_cnt * 255 > hi) begin
      fails++;
      $display("FAIL R2 R9 code %0d: actual %0d Hz expected %0d Hz", code, cyc_cnt, nom / 255);
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lfsr;
    m_phase = 0; m_cur = inc_of(0); m_code = 0; m_cnt = SYM - 1; m_under = 0;
    prev_neg = 0; meas_on = 0; cyc_cnt = 0;
    repeat (4) @(negedge clk);
    check("R1 reset sample", int'(sample), 0);
    check("R1 reset underrun", int'(underrun), 0);
    rst = 0;
    check("R1 sample after release", int'(sample), 0);
    step(0, 8'h00, 0);
    step(1, 8'h00, 1);
    measure(8'h00);
    measure(8'h80);
    measure(8'hFF);
    lfsr = 32'h1ACE;
    for (int i = 0; i < 6000; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      step((lfsr & 8'h1C) != 0, 8'(lfsr >> 3), (lfsr & 3) != 0);
    end
    for (int i = 0; i < 3 * SYM; i++) step((i / SYM) != 1, 8'h40, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule